// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block takes one block-transfer instruction and turns it into a serial stream of micro-operations. It issues at most one micro-op per clock under a valid/ready handshake. The instruction is described by a register-selection mask, a base register index and five control bits: before/after addressing, increment/decrement direction, a privileged-transfer bit, base update and load/store.

For a legal instruction the stream is always in this order:
1. A micro-op that copies the base register into a fixed scratch register.
2. One load or store micro-op per selected register. Each of these addresses memory relative to the scratch register.
3. An optional micro-op that writes the updated base back.

Every micro-op carries an opcode, a destination index, a source index, an 8-bit offset, an add/subtract flag and a last marker. The downstream execution stage consumes the stream. The sequencer itself never touches memory or the register file.

Top module: `lsm_uop_seq`

## Requirements
- R1: The first micro-op of every legal instruction has opcode 0 (add immediate), destination 17 (scratch), source equal to the base index, offset 0, subtract flag 0 and last flag 0.
- R2: Transfer micro-ops name the selected registers in ascending index order, one micro-op per set bit of the mask.
- R3: The first transfer offset depends on the addressing mode. With N = number of set mask bits:
  - after/increment (pre=0, up=1) starts at 0
  - before/increment (pre=1, up=1) starts at 4
  - after/decrement (pre=0, up=0) starts at 4N-4
  - before/decrement (pre=1, up=0) starts at 4N
- R4: Every transfer micro-op has source 17. Its subtract flag is the inverse of the up bit, so the address is scratch + offset when up=1 and scratch - offset when up=0. Each following transfer offset is 4 larger when up=1 and 4 smaller when up=0.
- R5: Transfers have opcode 2 (load) when the load bit is 1 and opcode 3 (store) when it is 0.
- R6: With the base-update bit set, a final micro-op is issued with destination and source equal to the base index and offset 4N. Its opcode is 0 (add) with subtract flag 0 when up=1, and 1 (subtract) with subtract flag 1 when up=0. With the bit clear, no such micro-op is issued.
- R7: Exactly the final micro-op of a sequence carries last=1. That is the base-update micro-op if present, otherwise the final transfer.
- R8: An accepted instruction with the privileged-transfer bit set produces a one-cycle error pulse in the cycle after acceptance and issues no micro-op.
- R9: An accepted instruction with an all-zero mask behaves the same as R8.
- R10: Commands are accepted only while idle (cmd_ready=1, no micro-op pending). A presented micro-op holds all of its fields until uop_ready is high. After the last micro-op is taken, the sequencer is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Instruction present |
| cmd_ready | output | 1 | Sequencer idle, instruction taken when valid |
| cmd_mask | input | 16 | Register-selection mask, bit i selects register i |
| cmd_pre | input | 1 | 1 = address before transfer, 0 = after |
| cmd_up | input | 1 | 1 = increment, 0 = decrement |
| cmd_priv | input | 1 | Privileged-transfer bit (unsupported) |
| cmd_wb | input | 1 | Base update requested |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_base | input | 4 | Base register index |
| cmd_err | output | 1 | One-cycle pulse for a rejected instruction |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Downstream takes the micro-op |
| uop_op | output | 2 | 0 add-imm, 1 sub-imm, 2 load, 3 store |
| uop_dst | output | 5 | Destination / data register index |
| uop_src | output | 5 | Source / address register index |
| uop_ofs | output | 8 | Immediate offset |
| uop_sub | output | 1 | 1 = offset is subtracted |
| uop_last | output | 1 | Final micro-op of the sequence |

## Verification
The bench builds the block with its default parameters: a 16-bit mask, 5-bit register indices, 8-bit offsets and scratch register 17. Under these defaults the largest writeback amount, 64, still fits the offset field. The bench sweeps every combination of the four addressing modes, load/store and base update over walking-one masks, the full mask and a pseudo-random set of masks, with the base index rotating. Micro-op acceptance alternates between continuous and randomly stalled, so field holding and the return to idle are both reached. Rejected encodings are exercised both with the privileged bit and with an empty mask.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    UOP_ADDI  = 2'd0,
    UOP_SUBI  = 2'd1,
    UOP_LOAD  = 2'd2,
    UOP_STORE = 2'd3
  } uop_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_XFER = 2'd2,
    ST_WB   = 2'd3
  } seq_state_e;

  // offset of the first transfer for a given addressing mode and count
  function automatic int unsigned first_offset(bit pre, bit up, int unsigned n);
    unsigned_case: begin end
    if (up) return pre ? 4 : 0;
    return pre ? 4 * n : 4 * n - 4;
  endfunction

  // base adjustment applied by the writeback micro-op
  function automatic int unsigned base_step(int unsigned n);
    return 4 * n;
  endfunction

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int W   = 16,
  parameter int CNT = 5
) (
  input  logic [W-1:0]   vec,
  output logic [CNT-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CNT'(vec[i]);
  end
endmodule

// File: rtl/lsm_low_pick.sv
module lsm_low_pick #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign onehot = vec & (~vec + W'(1));
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_pkg::*;
#(
  parameter int LIST_W  = 16,
  parameter int RIDX_W  = 5,
  parameter int OFS_W   = 8,
  parameter int SCRATCH = 17
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [LIST_W-1:0]         cmd_mask,
  input  logic                      cmd_pre,
  input  logic                      cmd_up,
  input  logic                      cmd_priv,
  input  logic                      cmd_wb,
  input  logic                      cmd_load,
  input  logic [$clog2(LIST_W)-1:0] cmd_base,
  output logic                      cmd_err,
  output logic                      uop_valid,
  input  logic                      uop_ready,
  output logic [1:0]                uop_op,
  output logic [RIDX_W-1:0]         uop_dst,
  output logic [RIDX_W-1:0]         uop_src,
  output logic [OFS_W-1:0]          uop_ofs,
  output logic                      uop_sub,
  output logic                      uop_last
);
  localparam int BASE_W = $clog2(LIST_W);
  localparam int CNT_W  = $clog2(LIST_W + 1);
  localparam logic [RIDX_W-1:0] SCR_IDX = RIDX_W'(SCRATCH);
  localparam logic [OFS_W-1:0]  STEP    = OFS_W'(4);

  seq_state_e          state_q;
  logic [LIST_W-1:0]   mask_q;
  logic [OFS_W-1:0]    ofs_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                up_q, wb_q, load_q, err_q;
  logic [BASE_W-1:0]   base_q;

  logic [CNT_W-1:0]    cmd_cnt;
  logic [BASE_W-1:0]   pick_idx;
  logic [LIST_W-1:0]   pick_oh;

  lsm_popcount #(.W(LIST_W), .CNT(CNT_W)) u_pop (
    .vec(cmd_mask), .cnt(cmd_cnt)
  );

  lsm_low_pick #(.W(LIST_W), .IW(BASE_W)) u_pick (
    .vec(mask_q), .idx(pick_idx), .onehot(pick_oh)
  );

  // named events, also observed by the checker
  logic cmd_fire, cmd_bad, start_fire, uop_fire, xfer_fire, final_xfer;
  logic xfer_more, seq_done;

  assign cmd_ready  = (state_q == ST_IDLE);
  assign cmd_fire   = cmd_valid & cmd_ready;
  assign cmd_bad    = cmd_priv | (cmd_mask == '0);
  assign start_fire = cmd_fire & ~cmd_bad;
  assign uop_valid  = (state_q != ST_IDLE);
  assign uop_fire   = uop_valid & uop_ready;
  assign xfer_fire  = uop_fire & (state_q == ST_XFER);
  assign final_xfer = ((mask_q & ~pick_oh) == '0);
  assign xfer_more  = xfer_fire & ~final_xfer;
  assign seq_done   = uop_fire & uop_last;
  assign cmd_err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      ofs_q   <= '0;
      cnt_q   <= '0;
      up_q    <= 1'b0;
      wb_q    <= 1'b0;
      load_q  <= 1'b0;
      base_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= cmd_fire & cmd_bad;
      case (state_q)
        ST_IDLE: if (start_fire) begin
          state_q <= ST_COPY;
          mask_q  <= cmd_mask;
          cnt_q   <= cmd_cnt;
          ofs_q   <= OFS_W'(first_offset(cmd_pre, cmd_up, int'(cmd_cnt)));
          up_q    <= cmd_up;
          wb_q    <= cmd_wb;
          load_q  <= cmd_load;
          base_q  <= cmd_base;
        end
        ST_COPY: if (uop_fire) state_q <= ST_XFER;
        ST_XFER: if (uop_fire) begin
          mask_q <= mask_q & ~pick_oh;
          ofs_q  <= up_q ? ofs_q + STEP : ofs_q - STEP;
          if (final_xfer) state_q <= wb_q ? ST_WB : ST_IDLE;
        end
        ST_WB: if (uop_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  uop_kind_e kind;
  always_comb begin
    kind     = UOP_ADDI;
    uop_dst  = '0;
    uop_src  = '0;
    uop_ofs  = '0;
    uop_sub  = 1'b0;
    uop_last = 1'b0;
    case (state_q)
      ST_COPY: begin
        kind    = UOP_ADDI;
        uop_dst = SCR_IDX;
        uop_src = RIDX_W'(base_q);
      end
      ST_XFER: begin
        kind     = load_q ? UOP_LOAD : UOP_STORE;
        uop_dst  = RIDX_W'(pick_idx);
        uop_src  = SCR_IDX;
        uop_ofs  = ofs_q;
        uop_sub  = ~up_q;
        uop_last = ~wb_q & final_xfer;
      end
      ST_WB: begin
        kind     = up_q ? UOP_ADDI : UOP_SUBI;
        uop_dst  = RIDX_W'(base_q);
        uop_src  = RIDX_W'(base_q);
        uop_ofs  = OFS_W'(base_step(int'(cnt_q)));
        uop_sub  = ~up_q;
        uop_last = 1'b1;
      end
      default: ;
    endcase
  end
  assign uop_op = kind;

endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk #(
  parameter int RIDX_W  = 5,
  parameter int OFS_W   = 8,
  parameter int SCRATCH = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              cmd_err,
  input logic              uop_valid,
  input logic              uop_ready,
  input logic [1:0]        uop_op,
  input logic [RIDX_W-1:0] uop_dst,
  input logic [RIDX_W-1:0] uop_src,
  input logic [OFS_W-1:0]  uop_ofs,
  input logic              uop_sub,
  input logic              uop_last,
  input logic              xfer_more,
  input logic              seq_done
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid &&
      $stable({uop_op, uop_dst, uop_src, uop_ofs, uop_sub, uop_last}));

  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !uop_valid && cmd_ready);

  a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !uop_valid);

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_more |=> uop_ofs == ($past(uop_sub) ? $past(uop_ofs) - OFS_W'(4)
                                             : $past(uop_ofs) + OFS_W'(4)));

  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_more |=> uop_dst > $past(uop_dst));

  a_r4_scratch_src: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_op[1] |-> uop_src == RIDX_W'(SCRATCH));

  a_r7_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready && !uop_last |=> uop_valid);
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(
  .RIDX_W(RIDX_W), .OFS_W(OFS_W), .SCRATCH(SCRATCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
  .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
  .uop_dst(uop_dst), .uop_src(uop_src), .uop_ofs(uop_ofs),
  .uop_sub(uop_sub), .uop_last(uop_last), .xfer_more(xfer_more),
  .seq_done(seq_done)
);

// File: tb/test_lsm_uop_seq.sv
`timescale 1ns/1ps
module test_lsm_uop_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_pre = 1'b0, cmd_up = 1'b0, cmd_priv = 1'b0;
  logic        cmd_wb = 1'b0, cmd_load = 1'b0, uop_ready = 1'b0;
  logic [15:0] cmd_mask = '0;
  logic [3:0]  cmd_base = '0;
  logic        cmd_ready, cmd_err, uop_valid, uop_sub, uop_last;
  logic [1:0]  uop_op;
  logic [4:0]  uop_dst, uop_src;
  logic [7:0]  uop_ofs;

  always #2.5 clk = ~clk;

  lsm_uop_seq i_lsm_uop_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mask(cmd_mask), .cmd_pre(cmd_pre), .cmd_up(cmd_up), .cmd_priv(cmd_priv),
    .cmd_wb(cmd_wb), .cmd_load(cmd_load), .cmd_base(cmd_base), .cmd_err(cmd_err),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
    .uop_dst(uop_dst), .uop_src(uop_src), .uop_ofs(uop_ofs),
    .uop_sub(uop_sub), .uop_last(uop_last)
  );

  int n_cmp = 0, n_bad = 0;
  int e_len, e_op[19], e_dst[19], e_src[19], e_ofs[19], e_sub[19], e_last[19], e_kind[19];
  logic [7:0] stall_lfsr = 8'h5A;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected stream: transfer k of N computed directly from its rank
  task automatic build(logic [15:0] m, bit pre, bit up, bit wb, bit ld, int base);
    int n = 0, k = 0;
    for (int r = 0; r < 16; r++) n += m[r];
    e_kind[0] = 0; e_op[0] = 0; e_dst[0] = 17; e_src[0] = base;
    e_ofs[0] = 0; e_sub[0] = 0; e_last[0] = 0;
    for (int r = 0; r < 16; r++) begin
      if (m[r]) begin
        k++;
        e_kind[k] = (k == 1) ? 1 : 2;
        e_op[k]   = ld ? 2 : 3;
        e_dst[k]  = r;
        e_src[k]  = 17;
        if (up) e_ofs[k] = pre ? 4 * k : 4 * (k - 1);
        else    e_ofs[k] = pre ? 4 * (n - k + 1) : 4 * (n - k);
        e_sub[k]  = up ? 0 : 1;
        e_last[k] = (!wb && k == n) ? 1 : 0;
      end
    end
    e_len = n + 1;
    if (wb) begin
      e_kind[e_len] = 3; e_op[e_len] = up ? 0 : 1; e_dst[e_len] = base;
      e_src[e_len] = base; e_ofs[e_len] = 4 * n; e_sub[e_len] = up ? 0 : 1;
      e_last[e_len] = 1;
      e_len++;
    end
  endtask

  task automatic run(logic [15:0] m, bit pre, bit up, bit priv, bit wb, bit ld,
                     int base, bit stall);
    @(negedge clk);
    cmd_mask = m; cmd_pre = pre; cmd_up = up; cmd_priv = priv;
    cmd_wb = wb; cmd_load = ld; cmd_base = 4'(base); cmd_valid = 1'b1;
    uop_ready = 1'b0;
    check("R10 ready while idle", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (priv || m == '0) begin
      check(priv ? "R8 error pulse" : "R9 error pulse", int'(cmd_err), 1);
      check(priv ? "R8 no uop" : "R9 no uop", int'(uop_valid), 0);
      @(negedge clk);
      check(priv ? "R8 pulse ends" : "R9 pulse ends", int'(cmd_err), 0);
      check(priv ? "R8 still silent" : "R9 still silent", int'(uop_valid), 0);
      check("R10 idle after reject", int'(cmd_ready), 1);
    end else begin
      int idx = 0, guard = 0;
      build(m, pre, up, wb, ld, base);
      while (idx < e_len && guard < 400) begin
        stall_lfsr = {stall_lfsr[6:0], stall_lfsr[7] ^ stall_lfsr[5] ^ stall_lfsr[4] ^ stall_lfsr[3]};
        uop_ready = stall ? stall_lfsr[0] : 1'b1;
        check("R10 uop valid", int'(uop_valid), 1);
        check("R10 busy not ready", int'(cmd_ready), 0);
        check("R7 last flag", int'(uop_last), e_last[idx]);
        case (e_kind[idx])
          0: begin
            check("R1 copy op", int'(uop_op), e_op[idx]);
            check("R1 copy dst", int'(uop_dst), e_dst[idx]);
            check("R1 copy src", int'(uop_src), e_src[idx]);
            check("R1 copy ofs", int'(uop_ofs), e_ofs[idx]);
            check("R1 copy sub", int'(uop_sub), e_sub[idx]);
          end
          1, 2: begin
            check("R5 xfer op", int'(uop_op), e_op[idx]);
            check("R2 xfer reg", int'(uop_dst), e_dst[idx]);
            check("R4 xfer src", int'(uop_src), e_src[idx]);
            check(e_kind[idx] == 1 ? "R3 first ofs" : "R4 next ofs", int'(uop_ofs), e_ofs[idx]);
            check("R4 xfer sub", int'(uop_sub), e_sub[idx]);
          end
          default: begin
            check("R6 wb op", int'(uop_op), e_op[idx]);
            check("R6 wb dst", int'(uop_dst), e_dst[idx]);
            check("R6 wb src", int'(uop_src), e_src[idx]);
            check("R6 wb ofs", int'(uop_ofs), e_ofs[idx]);
            check("R6 wb sub", int'(uop_sub), e_sub[idx]);
          end
        endcase
        if (uop_ready) idx++;
        @(negedge clk);
        guard++;
      end
      uop_ready = 1'b0;
      check("R10 idle after last", int'(uop_valid), 0);
      check("R10 ready after last", int'(cmd_ready), 1);
      check("R7 no extra uop", idx, e_len);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    int iter = 0;
    repeat (3) @(negedge clk);
    check("R10 reset uop_valid", int'(uop_valid), 0);
    check("R10 reset cmd_ready", int'(cmd_ready), 1);
    check("R8 reset cmd_err", int'(cmd_err), 0);
    rst_n = 1'b1;

    for (int t = 0; t < 60; t++) begin
      logic [15:0] m;
      if (t < 16) m = 16'(1) << t;
      else if (t == 16) m = 16'hFFFF;
      else if (t == 17) m = 16'h8001;
      else begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        m = lf;
      end
      for (int c = 0; c < 16; c++) begin
        run(m, c[0], c[1], 1'b0, c[2], c[3], iter % 16, iter[0]);
        iter++;
      end
    end
    for (int c = 0; c < 8; c++) begin
      run(16'h00F0, c[0], c[1], 1'b1, c[2], 1'b1, c, 1'b0);
      run(16'h0000, c[0], c[1], 1'b0, c[2], 1'b0, c, 1'b0);
    end
    run(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 15, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule